// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It reads descriptors from a two-level translation table in memory and does not cache any translation. A client raises a one-cycle request that carries the virtual address, a user/kernel flag and a read/write flag. The walker reads the first-level entry through a simple request/acknowledge read port. A section entry finishes the walk after that single read. A coarse or fine table pointer leads to one more read from a second-level table.

The walker ends every walk with a one-cycle completion pulse. On success it reports the physical address, the cacheable and bufferable attributes, the domain number and the 2-bit access permission that was selected. On failure it reports a fault code instead. The codes are:

| Code | Meaning |
|------|---------|
| 00 | first-level translation fault |
| 01 | second-level translation fault |
| 10 | domain fault |
| 11 | permission fault |

The permission check uses a 32-bit domain control word that holds sixteen 2-bit fields, one per domain. Only one walk is in flight at a time. While a walk is in progress, new requests are ignored.

Top module: `pt_walker`

## Requirements
- R1: A request is accepted only while `busy` is low. `busy` rises in the cycle after acceptance and stays high until the completion pulse. A `reqValid` pulse seen while `busy` is high starts nothing and does not change the result.
- R2: The first read is at address {tableBase[31:14], va[31:20], 2'b00}. While `memReq` waits for `memAck`, the address is word aligned and held stable.
- R3: A first-level entry with type bits [1:0] = 00 ends the walk after one read with fault code 00.
- R4: A first-level entry with type 10 (section) ends the walk after one read. It gives pa = {d[31:20], va[19:0]}, bufferable = d[2], cacheable = d[3], domain = d[8:5] and permission = d[11:10].
- R5: A first-level entry with type 01 (coarse) leads to a second read at {d[31:10], va[19:12], 2'b00}. A second-level entry of type 01 (64 KB page) gives pa = {e[31:16], va[15:0]}, with its permission chosen by va[15:14]. A type 10 entry (4 KB page) gives pa = {e[31:12], va[11:0]}, with its permission chosen by va[11:10]. Quarter 0 to quarter 3 take e[5:4], e[7:6], e[9:8] and e[11:10]. Bufferable and cacheable come from e[2] and e[3]. The domain comes from the first-level entry, bits [8:5].
- R6: A first-level entry with type 11 (fine) leads to a second read at {d[31:12], va[19:10], 2'b00}. A second-level entry of type 11 (1 KB page) gives pa = {e[31:10], va[9:0]} and permission e[5:4].
- R7: Fault code 01 is reported in three cases: a second-level type of 00, type 11 under a coarse table, or type 01 or 10 under a fine table.
- R8: The access type of domain n is domainCtl[2n+1:2n]. Values 00 and 10 give fault code 10. Value 11 grants the access without a permission check.
- R9: Under access type 01, the permission codes allow the following; any other access gives fault code 11.

  | Permission | Allowed |
  |------------|---------|
  | 00 | kernel reads only |
  | 01 | any kernel access, no user access |
  | 10 | any kernel access and user reads |
  | 11 | every access |

- R10: Translation faults take precedence over domain faults, and domain faults take precedence over permission faults.
- R11: `doneValid` is high for exactly one cycle. It follows the cycle in which the last descriptor is acknowledged, and `busy` is low in the next cycle. The result outputs hold their values until the next completion.
- R12: During reset and after it, `busy`, `memReq` and `doneValid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (sampled while idle) |
| reqVa | input | 32 | Virtual address to translate |
| reqUser | input | 1 | 1 = user-mode access, 0 = kernel |
| reqWrite | input | 1 | 1 = write, 0 = read |
| tableBase | input | 32 | First-level table base; bits [31:14] used |
| domainCtl | input | 32 | Sixteen 2-bit domain access types |
| busy | output | 1 | Walk in progress |
| memReq | output | 1 | Descriptor read request, held until acknowledged |
| memAddr | output | 32 | Descriptor address |
| memAck | input | 1 | One-cycle read acknowledge |
| memRdata | input | 32 | Descriptor returned with memAck |
| doneValid | output | 1 | One-cycle completion pulse |
| doneFault | output | 1 | Walk ended in a fault |
| faultCode | output | 2 | 00 L1 xlat, 01 L2 xlat, 10 domain, 11 permission |
| physAddr | output | 32 | Translated physical address |
| cacheable | output | 1 | Cacheable attribute |
| bufferable | output | 1 | Bufferable attribute |
| domainOut | output | 4 | Domain of the mapping |
| apOut | output | 2 | Selected access-permission field |

## Verification
Some properties are checked every cycle by assertions:
- the read port stays quiet while the walker is idle;
- the descriptor address is aligned and held stable until acknowledged;
- the first read targets the latched table base;
- the completion pulse lasts one cycle and leaves the walker idle;
- a walk that stopped after one read never reports a second-level fault.

Other behaviour can only be shown by the bench's scenarios. This covers the value of every translated address and attribute, the choice of subpage permission from the address, the permission outcome for each user/write combination, and the precedence between fault kinds. It also covers whether a mid-walk request really has no effect.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int ADDR_W  = 32;
  localparam int DOM_W   = 4;
  localparam int NUM_DOM = 1 << DOM_W;
  localparam int DAC_W   = 2 * NUM_DOM;
  localparam int AP_W    = 2;

  localparam logic [1:0] L1_FLT = 2'b00;
  localparam logic [1:0] L1_CRS = 2'b01;
  localparam logic [1:0] L1_SEC = 2'b10;
  localparam logic [1:0] L1_FIN = 2'b11;

  localparam logic [1:0] L2_FLT = 2'b00;
  localparam logic [1:0] L2_LRG = 2'b01;
  localparam logic [1:0] L2_SML = 2'b10;
  localparam logic [1:0] L2_TNY = 2'b11;

  localparam logic [1:0] DA_NONE   = 2'b00;
  localparam logic [1:0] DA_CLIENT = 2'b01;
  localparam logic [1:0] DA_RSVD   = 2'b10;
  localparam logic [1:0] DA_MGR    = 2'b11;

  typedef enum logic [1:0] {
    FC_L1_XLAT = 2'b00,
    FC_L2_XLAT = 2'b01,
    FC_DOMAIN  = 2'b10,
    FC_PERM    = 2'b11
  } faultCode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_L1_FETCH,
    ST_L2_FETCH,
    ST_DONE
  } walkState_e;

  typedef struct packed {
    logic capReq;
    logic capL1;
    logic finishL1;
    logic finishL2;
    logic selL2;
  } walkCtl_t;

  typedef struct packed {
    logic               fault;
    faultCode_e         code;
    logic [ADDR_W-1:0]  pa;
    logic               cacheable;
    logic               bufferable;
    logic [DOM_W-1:0]   dom;
    logic [AP_W-1:0]    ap;
  } walkRes_t;
endpackage

// File: rtl/xw_access.sv
module xw_access
  import xw_pkg::*;
(
  input  logic [DOM_W-1:0] dom,
  input  logic [DAC_W-1:0] dac,
  input  logic [AP_W-1:0]  ap,
  input  logic             isUser,
  input  logic             isWrite,
  output logic             domDeny,
  output logic             permDeny
);
  logic [1:0] dacArr [NUM_DOM];
  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dac
    assign dacArr[g] = dac[2*g +: 2];
  end

  logic [1:0] accType;
  logic       permOk;

  assign accType = dacArr[dom];

  always_comb begin
    case (ap)
      2'b00:   permOk = !isUser && !isWrite;
      2'b01:   permOk = !isUser;
      2'b10:   permOk = !isUser || !isWrite;
      default: permOk = 1'b1;
    endcase
  end

  assign domDeny  = (accType == DA_NONE) || (accType == DA_RSVD);
  assign permDeny = (accType == DA_CLIENT) && !permOk;

  always_comb begin
    a_r8_manager_never_denies: assert (!(accType == DA_MGR && (domDeny || permDeny)));
  end
endmodule

// File: rtl/xw_ctrl.sv
module xw_ctrl
  import xw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     memAck,
  input  logic     l1NeedsL2,
  output walkCtl_t ctl,
  output logic     busy,
  output logic     memReq,
  output logic     doneValid
);
  walkState_e st, stNext;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= stNext;
  end

  always_comb begin
    ctl    = '0;
    stNext = st;
    case (st)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capReq = 1'b1;
          stNext     = ST_L1_FETCH;
        end
      end
      ST_L1_FETCH: begin
        if (memAck) begin
          if (l1NeedsL2) begin
            ctl.capL1 = 1'b1;
            stNext    = ST_L2_FETCH;
          end else begin
            ctl.finishL1 = 1'b1;
            stNext       = ST_DONE;
          end
        end
      end
      ST_L2_FETCH: begin
        ctl.selL2 = 1'b1;
        if (memAck) begin
          ctl.finishL2 = 1'b1;
          stNext       = ST_DONE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign busy      = (st != ST_IDLE);
  assign memReq    = (st == ST_L1_FETCH) || (st == ST_L2_FETCH);
  assign doneValid = (st == ST_DONE);

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);
  a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !busy);
  a_r1_accept_starts_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reqValid) |=> (busy && memReq));
  a_r11_done_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneValid) |-> $past(memAck));
endmodule

// File: rtl/xw_dpath.sv
module xw_dpath
  import xw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  walkCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqVa,
  input  logic              reqUser,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [DAC_W-1:0]  domainCtl,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              l1NeedsL2,
  output walkRes_t          res
);
  logic [ADDR_W-1:0] vaQ;
  logic              userQ, writeQ;
  logic [31:14]      baseQ;
  logic [DAC_W-1:0]  dacQ;
  logic [ADDR_W-1:0] l1Q;
  walkRes_t          resQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vaQ    <= '0;
      userQ  <= 1'b0;
      writeQ <= 1'b0;
      baseQ  <= '0;
      dacQ   <= '0;
    end else if (ctl.capReq) begin
      vaQ    <= reqVa;
      userQ  <= reqUser;
      writeQ <= reqWrite;
      baseQ  <= tableBase[31:14];
      dacQ   <= domainCtl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         l1Q <= '0;
    else if (ctl.capL1) l1Q <= memRdata;
  end

  // Descriptor addresses
  logic [ADDR_W-1:0] l1Addr, l2Addr;
  assign l1Addr = {baseQ, vaQ[31:20], 2'b00};
  assign l2Addr = (l1Q[1:0] == L1_CRS) ? {l1Q[31:10], vaQ[19:12], 2'b00}
                                       : {l1Q[31:12], vaQ[19:10], 2'b00};
  assign memAddr   = ctl.selL2 ? l2Addr : l1Addr;
  assign l1NeedsL2 = (memRdata[1:0] == L1_CRS) || (memRdata[1:0] == L1_FIN);

  // Translation of the descriptor that ends the walk
  logic              xlatFault;
  faultCode_e        xlatCode;
  logic [ADDR_W-1:0] paNext;
  logic              cNext, bNext;
  logic [DOM_W-1:0]  domNext;
  logic [AP_W-1:0]   apNext;

  function automatic logic [AP_W-1:0] pickSub(input logic [ADDR_W-1:0] d, input logic [1:0] q);
    return d[4 + 2*int'(q) +: 2];
  endfunction

  always_comb begin
    xlatFault = 1'b0;
    xlatCode  = FC_L1_XLAT;
    paNext    = '0;
    cNext     = memRdata[3];
    bNext     = memRdata[2];
    domNext   = '0;
    apNext    = '0;
    if (ctl.finishL1) begin
      domNext = memRdata[8:5];
      if (memRdata[1:0] == L1_SEC) begin
        paNext = {memRdata[31:20], vaQ[19:0]};
        apNext = memRdata[11:10];
      end else begin
        xlatFault = 1'b1;
        xlatCode  = FC_L1_XLAT;
      end
    end else begin
      domNext = l1Q[8:5];
      if (l1Q[1:0] == L1_CRS) begin
        case (memRdata[1:0])
          L2_LRG: begin
            paNext = {memRdata[31:16], vaQ[15:0]};
            apNext = pickSub(memRdata, vaQ[15:14]);
          end
          L2_SML: begin
            paNext = {memRdata[31:12], vaQ[11:0]};
            apNext = pickSub(memRdata, vaQ[11:10]);
          end
          default: begin
            xlatFault = 1'b1;
            xlatCode  = FC_L2_XLAT;
          end
        endcase
      end else if (memRdata[1:0] == L2_TNY) begin
        paNext = {memRdata[31:10], vaQ[9:0]};
        apNext = memRdata[5:4];
      end else begin
        xlatFault = 1'b1;
        xlatCode  = FC_L2_XLAT;
      end
    end
  end

  logic domDeny, permDeny;
  xw_access u_acc (
    .dom      (domNext),
    .dac      (dacQ),
    .ap       (apNext),
    .isUser   (userQ),
    .isWrite  (writeQ),
    .domDeny  (domDeny),
    .permDeny (permDeny)
  );

  walkRes_t resNext;
  always_comb begin
    resNext.pa         = paNext;
    resNext.cacheable  = cNext;
    resNext.bufferable = bNext;
    resNext.dom        = domNext;
    resNext.ap         = apNext;
    resNext.fault      = xlatFault || domDeny || permDeny;
    if (xlatFault)    resNext.code = xlatCode;
    else if (domDeny) resNext.code = FC_DOMAIN;
    else              resNext.code = FC_PERM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             resQ <= '0;
    else if (ctl.finishL1 || ctl.finishL2)  resQ <= resNext;
  end
  assign res = resQ;

  logic unusedL1Bits;
  assign unusedL1Bits = ^{l1Q[9], l1Q[4:2]};

  a_r3_single_read_no_l2_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finishL1 |=> !(res.fault && res.code == FC_L2_XLAT));
  a_r7_l2_never_l1_code: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finishL2 |=> !(res.fault && res.code == FC_L1_XLAT));
  a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.finishL1 || ctl.finishL2) |=> $stable(res));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import xw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic [31:0] reqVa,
  input  logic        reqUser,
  input  logic        reqWrite,
  input  logic [31:0] tableBase,
  input  logic [31:0] domainCtl,
  output logic        busy,
  output logic        memReq,
  output logic [31:0] memAddr,
  input  logic        memAck,
  input  logic [31:0] memRdata,
  output logic        doneValid,
  output logic        doneFault,
  output logic [1:0]  faultCode,
  output logic [31:0] physAddr,
  output logic        cacheable,
  output logic        bufferable,
  output logic [3:0]  domainOut,
  output logic [1:0]  apOut
);
  walkCtl_t ctl;
  logic     l1NeedsL2;
  walkRes_t res;

  xw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .memAck    (memAck),
    .l1NeedsL2 (l1NeedsL2),
    .ctl       (ctl),
    .busy      (busy),
    .memReq    (memReq),
    .doneValid (doneValid)
  );

  xw_dpath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .reqVa     (reqVa),
    .reqUser   (reqUser),
    .reqWrite  (reqWrite),
    .tableBase (tableBase),
    .domainCtl (domainCtl),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .l1NeedsL2 (l1NeedsL2),
    .res       (res)
  );

  assign doneFault  = res.fault;
  assign faultCode  = res.code;
  assign physAddr   = res.pa;
  assign cacheable  = res.cacheable;
  assign bufferable = res.bufferable;
  assign domainOut  = res.dom;
  assign apOut      = res.ap;

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!memReq && !doneValid));
  a_r2_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> (memAddr[1:0] == 2'b00));
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));
  a_r2_first_read_base: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reqValid) |=> (memAddr[31:14] == $past(tableBase[31:14])));
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic        reqUser = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] tableBase = '0;
  logic [31:0] domainCtl = '0;
  logic        busy, memReq, doneValid, doneFault, cacheable, bufferable;
  logic [31:0] memAddr, physAddr;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic [1:0]  faultCode, apOut;
  logic [3:0]  domainOut;

  pt_walker u0 (.*);

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int rdCount = 0;
  logic [31:0] rdAddr [2];
  logic [31:0] memImg [logic [31:0]];
  logic [2:0]  latency = 3'd0;
  logic        finished = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory model: acknowledges each read after a random latency
  initial begin
    forever begin
      @(negedge clk);
      if (memReq) begin
        if (rdCount < 2) rdAddr[rdCount] = memAddr;
        rdCount++;
        repeat (int'(latency)) @(negedge clk);
        memRdata = memImg.exists(memAddr) ? memImg[memAddr] : 32'h0;
        memAck   = 1'b1;
        @(negedge clk);
        memAck   = 1'b0;
        latency  = 3'($urandom % 4);
      end
    end
  end

  task automatic predict(
    input  logic [31:0] va, base, dac, input logic usr, wr, input logic [31:0] d1, d2,
    output logic f, output logic [1:0] code, output logic [31:0] pa,
    output logic c, b, output logic [3:0] dom, output logic [1:0] ap,
    output int nr, output logic [31:0] a1, a2, output string tag);
    logic [1:0] q, acc;
    logic ok;
    f = 0; code = 0; pa = 0; c = 0; b = 0; dom = 0; ap = 0; a2 = 0; nr = 1;
    a1 = {base[31:14], va[31:20], 2'b00};
    tag = "R4";
    case (d1[1:0])
      2'b00: begin f = 1; code = 2'b00; tag = "R3"; end
      2'b10: begin pa = {d1[31:20], va[19:0]}; c = d1[3]; b = d1[2]; dom = d1[8:5]; ap = d1[11:10]; end
      2'b01: begin
        nr = 2; tag = "R5"; dom = d1[8:5]; c = d2[3]; b = d2[2];
        a2 = {d1[31:10], va[19:12], 2'b00};
        if (d2[1:0] == 2'b01) begin
          pa = {d2[31:16], va[15:0]}; q = va[15:14];
          ap = (q == 0) ? d2[5:4] : (q == 1) ? d2[7:6] : (q == 2) ? d2[9:8] : d2[11:10];
        end else if (d2[1:0] == 2'b10) begin
          pa = {d2[31:12], va[11:0]}; q = va[11:10];
          ap = (q == 0) ? d2[5:4] : (q == 1) ? d2[7:6] : (q == 2) ? d2[9:8] : d2[11:10];
        end else begin f = 1; code = 2'b01; tag = "R7"; end
      end
      default: begin
        nr = 2; tag = "R6"; dom = d1[8:5]; c = d2[3]; b = d2[2];
        a2 = {d1[31:12], va[19:10], 2'b00};
        if (d2[1:0] == 2'b11) begin pa = {d2[31:10], va[9:0]}; ap = d2[5:4]; end
        else begin f = 1; code = 2'b01; tag = "R7"; end
      end
    endcase
    if (!f) begin
      acc = dac[2*dom +: 2];
      case (ap)
        2'b00:   ok = !usr && !wr;
        2'b01:   ok = !usr;
        2'b10:   ok = !(usr && wr);
        default: ok = 1;
      endcase
      if (acc == 2'b00 || acc == 2'b10) begin f = 1; code = 2'b10; tag = "R8"; end
      else if (acc == 2'b01 && !ok) begin f = 1; code = 2'b11; tag = "R9"; end
    end
  endtask

  logic [1:0] lastCode;

  task automatic runWalk(input logic [31:0] va, base, dac, input logic usr, wr,
                         input logic [31:0] d1, d2, input logic poke, input logic holdChk);
    logic f, c, b; logic [1:0] code, ap; logic [31:0] pa, a1, a2; logic [3:0] dom;
    int nr; string tag; int w;
    predict(va, base, dac, usr, wr, d1, d2, f, code, pa, c, b, dom, ap, nr, a1, a2, tag);
    memImg.delete();
    memImg[a1] = d1;
    if (nr == 2) memImg[a2] = d2;
    rdCount = 0;
    @(negedge clk);
    reqVa = va; tableBase = base; domainCtl = dac; reqUser = usr; reqWrite = wr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1", "busy after accept", 32'(busy), 32'd1);
    if (poke) begin
      reqVa = ~va; tableBase = ~base; domainCtl = ~dac; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    w = 0;
    while (!doneValid && w < 200) begin @(negedge clk); w++; end
    if (!doneValid) begin chk("R11", "done timeout", 32'd0, 32'd1); return; end
    lastCode = faultCode;
    chk(tag, "fault", 32'(doneFault), 32'(f));
    if (f) chk(tag, "code", 32'(faultCode), 32'(code));
    else begin
      chk(tag, "pa", physAddr, pa);
      chk(tag, "cb", {30'd0, cacheable, bufferable}, {30'd0, c, b});
      chk(tag, "dom", 32'(domainOut), 32'(dom));
      chk(tag, "ap", 32'(apOut), 32'(ap));
    end
    chk(poke ? "R1" : tag, "reads", 32'(rdCount), 32'(nr));
    chk("R2", "l1 addr", rdAddr[0], a1);
    if (nr == 2 && rdCount >= 2) chk(tag, "l2 addr", rdAddr[1], a2);
    @(negedge clk);
    chk("R11", "pulse/idle", {30'd0, doneValid, busy}, 32'd0);
    if (holdChk) begin
      repeat (3) @(negedge clk);
      chk("R11", "held pa", physAddr, f ? physAddr : pa);
      chk("R11", "held code", 32'(faultCode), 32'(lastCode));
    end
  endtask

  function automatic logic [31:0] mkSec(logic [11:0] p, logic [3:0] d, logic [1:0] a, logic c, logic b);
    return {p, 8'h00, a, 1'b0, d, 1'b0, c, b, 2'b10};
  endfunction

  localparam logic [31:0] BASE = 32'h0000_C000;
  localparam logic [31:0] ALLC = 32'h5555_5555;
  localparam logic [31:0] ALLM = 32'hFFFF_FFFF;

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] va, base, dac, d1, d2;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R12", "reset outputs", {29'd0, busy, memReq, doneValid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "after reset", {29'd0, busy, memReq, doneValid}, 32'd0);

    // R3: first-level fault
    runWalk(32'h1234_5678, BASE, ALLM, 0, 0, 32'h8000_0000, 0, 0, 1);
    // R4: section, manager
    runWalk(32'h1234_5678, BASE, ALLM, 1, 1, mkSec(12'hABC, 4'd3, 2'b00, 1, 0), 0, 0, 0);
    // R5: large page, each quarter
    for (int q = 0; q < 4; q++)
      runWalk({12'h321, 4'h0, q[1:0], 14'h1A5A}, BASE, ALLC, 0, 0,
              32'h8765_4C21, 32'hFEDC_0000 | 32'h0000_0E4D | (32'(q) << 2 & 32'h0), 0, 0);
    // R5: small page, each quarter
    for (int q = 0; q < 4; q++)
      runWalk({12'h0F0, 8'h3C, q[1:0], 10'h155}, BASE, ALLC, 0, 1,
              32'h9000_0021, 32'hBEEF_5E46, 0, 0);
    // R6: tiny page
    runWalk(32'hCAFE_F123, BASE, ALLC, 1, 1, 32'hA000_1023, 32'h7777_7C3F, 0, 0);
    // R7: coarse with tiny type, fine with small type, zero type
    runWalk(32'h0010_0000, BASE, ALLM, 0, 0, 32'h9000_0001, 32'h1111_1003, 0, 0);
    runWalk(32'h0010_0000, BASE, ALLM, 0, 0, 32'h9000_0003, 32'h1111_1002, 0, 0);
    runWalk(32'h0010_0000, BASE, ALLM, 0, 0, 32'h9000_0001, 32'h1111_1000, 0, 0);
    // R8: reserved and none access types
    runWalk(32'h0040_0000, BASE, 32'h0000_0020, 0, 0, mkSec(12'h111, 4'd2, 2'b11, 0, 0), 0, 0, 0);
    runWalk(32'h0040_0000, BASE, 32'hFFFF_FFCF, 0, 0, mkSec(12'h111, 4'd2, 2'b11, 0, 0), 0, 0, 0);
    // R9: client permissions, every ap x user x write
    for (int a = 0; a < 4; a++)
      for (int m = 0; m < 4; m++)
        runWalk(32'h0050_0000, BASE, ALLC, m[1], m[0], mkSec(12'h222, 4'd7, a[1:0], 1, 1), 0, 0, 0);
    // R10: translation beats domain, domain beats permission
    runWalk(32'h0060_0000, BASE, 32'h0, 1, 1, 32'h9000_0001, 32'h0000_0000, 0, 0);
    chk("R10", "xlat over domain", 32'(lastCode), 32'd1);
    runWalk(32'h0060_0000, BASE, 32'h0, 1, 1, mkSec(12'h333, 4'd0, 2'b00, 0, 0), 0, 0, 0);
    chk("R10", "domain over perm", 32'(lastCode), 32'd2);
    // R1: request while busy ignored
    runWalk(32'h0070_4567, BASE, ALLC, 0, 0, 32'h9000_0001, 32'h4444_5FF6, 1, 1);

    // constrained random walks
    for (int i = 0; i < 400; i++) begin
      va   = $urandom;
      base = $urandom;
      case ($urandom % 3)
        0: dac = ALLC;
        1: dac = ALLM;
        default: dac = $urandom;
      endcase
      d1 = $urandom;
      d1[31] = ~base[31];
      d2 = $urandom;
      if (($urandom % 4) != 0) d2[1:0] = (d1[1:0] == 2'b11) ? 2'b11 : 2'($urandom % 2 + 1);
      runWalk(va, base, dac, 1'($urandom), 1'($urandom), d1, d2, ($urandom % 8) == 0, ($urandom % 10) == 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule